// File: doc/BRIEF.md
# Phase-Bit Command Ring Consumer

This block is the hardware end of an eight-slot command ring that software fills with enqueue commands. Each slot holds a command, and the block keeps that command's leading header word. Software writes the body bytes of a slot first. It writes the opcode byte (byte 0) last. Bit 7 of that byte is a phase flag. The block reads the slot its consumer index points at. It takes that command only when the phase flag equals the polarity expected for the current lap. This polarity is 1 on the first lap and inverts each time the slot number wraps back to zero. So software needs no separate doorbell write for each command.

The consumer index and a producer index that the block follows from the stream of opcode-byte writes are both one bit wider than the slot number. They run modulo 16. This lets a full ring be told apart from an empty one, and the block reports the free space from the two indices. Execution is abstracted: each consumed command leaves as a one-cycle strobe. The strobe carries the slot number, the opcode byte, the completion-steering byte (byte 1: bit 7 is the enable, bits 3:0 are the index) and the whole stored header word. A downstream ready input lets the execution engine stall consumption. The opcode byte passes through unchanged. Its low two bits are the response mode, bit 2 enables order restoration, bit 3 requests an interrupt on dispatch and bit 4 selects the target type.

Top module: `vbring_cmd_ring`

## Requirements
- R1: After reset, cons_idx and prod_idx are 0, free_slots is 8 and exec_valid is 0; the expected phase for the first lap is 1.
- R2: The slot at cons_idx[2:0] is consumed only when bit 7 of its byte 0 equals the inverse of cons_idx[3] (1 on even laps, 0 on odd laps); a slot holding the other polarity is left alone.
- R3: Commands are consumed strictly in slot order, at most one per clock, and exec_slot gives the slot number of the command on the strobe.
- R4: With exec_valid, exec_hdr is the slot's stored header word at the time of consumption, exec_verb is its byte 0, exec_dca_en is bit 7 of byte 1 and exec_dca_idx is bits 3:0 of byte 1.
- R5: cons_idx increments by one modulo 16 on the same edge that raises exec_valid and holds otherwise.
- R6: prod_idx increments by one modulo 16 when a write with wr_be bit 0 set targets slot prod_idx[2:0] with data bit 7 equal to the inverse of prod_idx[3] while free_slots is nonzero; every other write leaves it unchanged.
- R7: free_slots is 8 minus the cyclic distance from cons_idx to prod_idx. That distance is prod_idx minus cons_idx when cons_idx ≤ prod_idx, and 16 minus (cons_idx minus prod_idx) otherwise. While free_slots is 0, no write advances prod_idx.
- R8: While exec_ready is low, nothing is consumed and the pending slot waits.
- R9: An opcode-byte write with the expected phase that is sampled at clock edge k is consumed, and exec_valid rises, at edge k+1, provided exec_ready is high at edge k+1 and that slot is the one cons_idx points at.
- R10: A write whose wr_be bit 0 is clear (a body-only write) never makes a slot consumable and never moves prod_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software write strobe into the ring |
| wr_slot | input | 3 | Slot addressed by the write |
| wr_be | input | 8 | Byte enables for the header word; bit 0 is the opcode byte |
| wr_data | input | 64 | Header word write data |
| exec_ready | input | 1 | Execution engine can accept a command this cycle |
| exec_valid | output | 1 | One-cycle strobe for a consumed command |
| exec_slot | output | 3 | Slot number of the consumed command |
| exec_verb | output | 8 | Opcode byte of the consumed command |
| exec_dca_en | output | 1 | Completion-steering enable from byte 1 |
| exec_dca_idx | output | 4 | Completion-steering index from byte 1 |
| exec_hdr | output | 64 | Full header word of the consumed command |
| cons_idx | output | 4 | Consumer index with wrap bit |
| prod_idx | output | 4 | Tracked producer index with wrap bit |
| free_slots | output | 4 | Slots software may still fill |

## Verification
The bench uses the default build: eight slots and a 64-bit header word. Both indices are therefore four bits wide, and a few thousand cycles of traffic make each index cross its modulo-16 boundary many times. Every slot is consumed under both phase polarities. Long stretches with exec_ready held low let the ring fill to zero free slots, so the refused producer advance at a full ring is exercised, as well as wrong-phase and body-only writes that land on pending and free slots.

// File: rtl/vbring_pkg.sv
// Package: shared constants and the cyclic-span helper of the command ring.
// Assumes opcode byte at bits 7:0 and completion-steering byte at bits 15:8.
package vbring_pkg;

    localparam int PHASE_BIT   = 7;   // phase flag inside the opcode byte
    localparam int DCA_EN_BIT  = 15;  // steering enable in byte 1
    localparam int DCA_IDX_LSB = 8;   // steering index low bit in byte 1
    localparam int DCA_IDX_W   = 4;   // steering index width

    // Distance from first (included) to last (excluded) on an index space
    // of twice the ring size.
    function automatic int unsigned ring_span(input int unsigned first,
                                              input int unsigned last,
                                              input int unsigned slots);
        if (first <= last)
            return last - first;
        else
            return (2 * slots) - (first - last);
    endfunction

endpackage

// File: rtl/vbring_slot_store.sv
// Module: header-word storage for every ring slot, with byte-enabled writes
// and one asynchronous read port. Assumes HDR_W is a multiple of 8.
module vbring_slot_store #(
    parameter int SLOTS = 8,
    parameter int HDR_W = 64,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int BYTES = HDR_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic [BYTES-1:0] wr_be,
    input  logic [HDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_slot,
    output logic [HDR_W-1:0] rd_hdr
);

    logic [HDR_W-1:0] mem [SLOTS];
    logic [SLOTS-1:0] slot_sel;

    // Per-slot write select decode.
    for (genvar s = 0; s < SLOTS; s++) begin : g_sel
        assign slot_sel[s] = wr_en && (wr_slot == IDX_W'(s));
    end

    // Byte-enabled write of the selected slot; cleared at reset.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SLOTS; s++) begin
            if (!rst_n) begin
                mem[s] <= '0;
            end else if (slot_sel[s]) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (wr_be[b])
                        mem[s][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    // Read port feeding the consumer.
    assign rd_hdr = mem[rd_slot];

endmodule

// File: rtl/vbring_producer.sv
// Module: follows the software producer index from opcode-byte writes and
// derives the free-slot count. Assumes software fills slots in order.
module vbring_producer #(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic             wr_op_byte,
    input  logic             wr_phase,
    input  logic [PTR_W-1:0] cons_idx,
    output logic [PTR_W-1:0] prod_idx,
    output logic [PTR_W-1:0] free_slots
);

    logic        advance;
    int unsigned span;

    // Free space from the cyclic distance between the two indices.
    always_comb begin
        span = vbring_pkg::ring_span({{(32-PTR_W){1'b0}}, cons_idx},
                                     {{(32-PTR_W){1'b0}}, prod_idx},
                                     SLOTS);
        free_slots = PTR_W'(SLOTS - span);
    end

    // An in-order opcode write of the current producer phase publishes a slot.
    assign advance = wr_en && wr_op_byte
                  && (wr_slot == prod_idx[IDX_W-1:0])
                  && (wr_phase == ~prod_idx[IDX_W])
                  && (free_slots != '0);

    // Producer index register with wrap bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prod_idx <= '0;
        else if (advance)
            prod_idx <= prod_idx + PTR_W'(1);
    end

endmodule

// File: rtl/vbring_consumer.sv
// Module: consumes the slot at the consumer index when its phase flag matches
// the lap polarity and the engine is ready; registers the command strobe.
module vbring_consumer #(
    parameter int SLOTS = 8,
    parameter int HDR_W = 64,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HDR_W-1:0] rd_hdr,
    input  logic             exec_ready,
    output logic [PTR_W-1:0] cons_idx,
    output logic             exec_valid,
    output logic [IDX_W-1:0] exec_slot,
    output logic [HDR_W-1:0] exec_hdr
);

    logic take;

    // Expected phase is the inverse of the wrap bit: 1 on lap 0.
    assign take = exec_ready && (rd_hdr[vbring_pkg::PHASE_BIT] == ~cons_idx[IDX_W]);

    // Consumer index and registered command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cons_idx   <= '0;
            exec_valid <= 1'b0;
            exec_slot  <= '0;
            exec_hdr   <= '0;
        end else begin
            exec_valid <= take;
            if (take) begin
                cons_idx  <= cons_idx + PTR_W'(1);
                exec_slot <= cons_idx[IDX_W-1:0];
                exec_hdr  <= rd_hdr;
            end
        end
    end

endmodule

// File: rtl/vbring_cmd_ring.sv
// Module: top of the phase-bit command ring. Software writes header words;
// slots are consumed in order by phase flag and leave as a strobe.
// Assumes SLOTS is a power of two and HDR_W covers at least two bytes.
module vbring_cmd_ring #(
    parameter int SLOTS = 8,
    parameter int HDR_W = 64,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int PTR_W = IDX_W + 1,
    localparam int BYTES = HDR_W / 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_slot,
    input  logic [BYTES-1:0]               wr_be,
    input  logic [HDR_W-1:0]               wr_data,
    input  logic                           exec_ready,
    output logic                           exec_valid,
    output logic [IDX_W-1:0]               exec_slot,
    output logic [7:0]                     exec_verb,
    output logic                           exec_dca_en,
    output logic [vbring_pkg::DCA_IDX_W-1:0] exec_dca_idx,
    output logic [HDR_W-1:0]               exec_hdr,
    output logic [PTR_W-1:0]               cons_idx,
    output logic [PTR_W-1:0]               prod_idx,
    output logic [PTR_W-1:0]               free_slots
);

    logic [HDR_W-1:0] rd_hdr;

    vbring_slot_store #(.SLOTS(SLOTS), .HDR_W(HDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_slot (cons_idx[IDX_W-1:0]),
        .rd_hdr  (rd_hdr)
    );

    vbring_producer #(.SLOTS(SLOTS)) u_prod (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_op_byte (wr_be[0]),
        .wr_phase   (wr_data[vbring_pkg::PHASE_BIT]),
        .cons_idx   (cons_idx),
        .prod_idx   (prod_idx),
        .free_slots (free_slots)
    );

    vbring_consumer #(.SLOTS(SLOTS), .HDR_W(HDR_W)) u_cons (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_hdr     (rd_hdr),
        .exec_ready (exec_ready),
        .cons_idx   (cons_idx),
        .exec_valid (exec_valid),
        .exec_slot  (exec_slot),
        .exec_hdr   (exec_hdr)
    );

    // Field views of the consumed header word.
    assign exec_verb    = exec_hdr[7:0];
    assign exec_dca_en  = exec_hdr[vbring_pkg::DCA_EN_BIT];
    assign exec_dca_idx = exec_hdr[vbring_pkg::DCA_IDX_LSB +: vbring_pkg::DCA_IDX_W];

endmodule

// File: rtl/vbring_cmd_ring_chk.sv
// Module: protocol checker for the command ring, bound to the top module.
module vbring_cmd_ring_chk #(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int PTR_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_ready,
    input logic             exec_valid,
    input logic [IDX_W-1:0] exec_slot,
    input logic             exec_phase,
    input logic [PTR_W-1:0] cons_idx,
    input logic [PTR_W-1:0] prod_idx,
    input logic [PTR_W-1:0] free_slots
);

    AST_CI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> cons_idx == $past(cons_idx) + PTR_W'(1)); // R5

    AST_CI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |-> $stable(cons_idx)); // R5

    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> exec_slot == $past(cons_idx[IDX_W-1:0])); // R3

    AST_PHASE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> exec_phase == ~$past(cons_idx[IDX_W])); // R2

    AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(exec_ready) |-> !exec_valid); // R8

    AST_PI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_idx != $past(prod_idx)) |-> prod_idx == $past(prod_idx) + PTR_W'(1)); // R6

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(free_slots) == '0) |-> $stable(prod_idx)); // R7

endmodule

bind vbring_cmd_ring vbring_cmd_ring_chk #(.SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_ready (exec_ready),
    .exec_valid (exec_valid),
    .exec_slot  (exec_slot),
    .exec_phase (exec_verb[7]),
    .cons_idx   (cons_idx),
    .prod_idx   (prod_idx),
    .free_slots (free_slots)
);

// File: tb/test_vbring_cmd_ring.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, compared against
// a requirement-level ring model kept in the bench.
module test_vbring_cmd_ring;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_slot = '0;
    logic [7:0]  wr_be = '0;
    logic [63:0] wr_data = '0;
    logic        exec_ready = 1'b0;
    logic        exec_valid;
    logic [2:0]  exec_slot;
    logic [7:0]  exec_verb;
    logic        exec_dca_en;
    logic [3:0]  exec_dca_idx;
    logic [63:0] exec_hdr;
    logic [3:0]  cons_idx, prod_idx, free_slots;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] m_mem [8];
    logic [3:0]  m_ci, m_pi;

    always #2 clk = ~clk;

    vbring_cmd_ring i_vbring_cmd_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_be(wr_be), .wr_data(wr_data), .exec_ready(exec_ready),
        .exec_valid(exec_valid), .exec_slot(exec_slot), .exec_verb(exec_verb),
        .exec_dca_en(exec_dca_en), .exec_dca_idx(exec_dca_idx),
        .exec_hdr(exec_hdr), .cons_idx(cons_idx), .prod_idx(prod_idx),
        .free_slots(free_slots)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R7: free = 8 minus slots in use; the 4-bit difference wraps modulo 16.
    function automatic logic [3:0] exp_free(input logic [3:0] p, input logic [3:0] c);
        return 4'd8 - (p - c);
    endfunction

    // One clock of stimulus, model update and comparison.
    task automatic step(input bit we, input logic [2:0] sl, input logic [7:0] be,
                        input logic [63:0] d, input bit rdy);
        logic [63:0] cur;
        bit hit, adv;
        wr_en = we; wr_slot = sl; wr_be = be; wr_data = d; exec_ready = rdy;
        cur = m_mem[m_ci[2:0]];
        hit = rdy && (cur[7] == ~m_ci[3]);
        adv = we && be[0] && (sl == m_pi[2:0]) && (d[7] == ~m_pi[3])
              && (exp_free(m_pi, m_ci) != 4'd0);
        @(posedge clk);
        if (we)
            for (int b = 0; b < 8; b++)
                if (be[b]) m_mem[sl][b*8 +: 8] = d[b*8 +: 8];
        if (hit) m_ci = m_ci + 4'd1;
        if (adv) m_pi = m_pi + 4'd1;
        @(negedge clk);
        chk(exec_valid == hit, "R9 exec_valid (phase R2, ready R8, body R10)",
            64'(exec_valid), 64'(hit));
        if (hit) begin
            chk(exec_slot == cur_slot(m_ci), "R3 exec_slot", 64'(exec_slot), 64'(cur_slot(m_ci)));
            chk(exec_hdr == cur, "R4 exec_hdr", exec_hdr, cur);
            chk(exec_verb == cur[7:0], "R4 exec_verb", 64'(exec_verb), 64'(cur[7:0]));
            chk(exec_dca_en == cur[15], "R4 exec_dca_en", 64'(exec_dca_en), 64'(cur[15]));
            chk(exec_dca_idx == cur[11:8], "R4 exec_dca_idx", 64'(exec_dca_idx), 64'(cur[11:8]));
        end
        chk(cons_idx == m_ci, "R5 cons_idx", 64'(cons_idx), 64'(m_ci));
        chk(prod_idx == m_pi, "R6 prod_idx", 64'(prod_idx), 64'(m_pi));
        chk(free_slots == exp_free(m_pi, m_ci), "R7 free_slots",
            64'(free_slots), 64'(exp_free(m_pi, m_ci)));
        wr_en = 1'b0;
    endtask

    // Slot consumed just before the index moved to ci.
    function automatic logic [2:0] cur_slot(input logic [3:0] ci);
        return ci[2:0] - 3'd1;
    endfunction

    function automatic logic [63:0] op_word(input bit phase);
        logic [63:0] w;
        w = {$urandom, $urandom};
        w[7] = phase;
        return w;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        void'($urandom(32'h5EED_0011));
        for (int s = 0; s < 8; s++) m_mem[s] = '0;
        m_ci = '0;
        m_pi = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk(cons_idx == 4'd0, "R1 cons_idx", 64'(cons_idx), 64'd0);
        chk(prod_idx == 4'd0, "R1 prod_idx", 64'(prod_idx), 64'd0);
        chk(free_slots == 4'd8, "R1 free_slots", 64'(free_slots), 64'd8);
        chk(exec_valid == 1'b0, "R1 exec_valid", 64'(exec_valid), 64'd0);

        // R10: body-only write carrying a matching phase bit in data.
        step(1, 3'd0, 8'hFE, 64'hFFFF_FFFF_FFFF_FFFF, 1);
        step(0, 3'd0, 8'h00, 64'd0, 1);
        // R2: wrong-phase opcode write to slot 0.
        step(1, 3'd0, 8'h01, 64'h0000_0000_0000_0045, 1);
        step(0, 3'd0, 8'h00, 64'd0, 1);
        // R9 and R4: matching write, consumed the following edge.
        step(1, 3'd0, 8'hFF, 64'h1122_3344_5566_8A9B, 1);
        step(0, 3'd0, 8'h00, 64'd0, 1);

        // R8 and R7: fill the ring with the engine stalled.
        for (int k = 0; k < 8; k++) begin
            w = op_word(~m_pi[3]);
            step(1, m_pi[2:0], 8'hFF, w, 0);
        end
        // R7: full ring refuses to advance the producer index.
        step(1, m_pi[2:0], 8'h01, 64'h0000_0000_0000_0000, 0);
        // Restore the pending opcode byte of that slot (phase of this lap).
        step(1, m_ci[2:0], 8'h01, 64'h0000_0000_0000_0081 ^ 64'(~m_ci[3]) << 7 ^ 64'h80, 0);
        repeat (3) step(0, 3'd0, 8'h00, 64'd0, 0);
        // Drain.
        repeat (10) step(0, 3'd0, 8'h00, 64'd0, 1);

        // Random traffic across many laps.
        for (int i = 0; i < 4000; i++) begin
            int kind;
            bit rdy;
            logic [3:0] f;
            kind = int'($urandom % 10);
            f = exp_free(m_pi, m_ci);
            rdy = ((i % 64) < 20) ? 1'b0 : (($urandom % 4) != 0);
            if (kind < 5 && f != 4'd0)
                step(1, m_pi[2:0], 8'($urandom) | 8'h01, op_word(~m_pi[3]), rdy);
            else if (kind == 5 && f != 4'd0)
                step(1, m_pi[2:0], 8'h01, op_word(m_pi[3]), rdy);
            else if (kind == 6 || kind == 7)
                step(1, 3'($urandom), 8'($urandom) & 8'hFE, op_word(1'b1), rdy);
            else
                step(0, 3'd0, 8'h00, 64'd0, rdy);
        end
        repeat (12) step(0, 3'd0, 8'h00, 64'd0, 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule